// File: doc/BRIEF.md
# USB Dual-Role Controller Interrupt Glue

This block sits between a USB dual-role controller core and a CPU. It collects two groups of interrupt events into sticky source bits: per-endpoint transmit and receive events in one 32-bit group, and core-level USB events in a 9-bit field of a second 32-bit group. Each group has its own enable mask. Each source and each mask bit is changed only through separate write-one-to-set and write-one-to-clear registers. A read-only view shows the sources that are currently enabled.

The block drives one level interrupt line toward the CPU. After the line rises it stays disarmed until software writes the end-of-interrupt register, so a handler always sees one clean request for each service pass. The block also holds a nonzero revision word, a control register whose bit 0 is a soft reset, a status register with the synchronized VBUS-drive input, and four plain 32-bit storage registers for the core's emulation, auto-request, SRP timing and teardown settings. Every edge of the VBUS-drive input raises a core event. Software uses that event to track role changes.

The bus side is a simple single-cycle port. A write is taken on the clock edge where `reg_wr` is high, and read data follows `reg_addr` combinationally. Offsets are byte addresses. Only word-aligned addresses are decoded.

Top module: `otg_glue_irqc`

## Requirements
- R1: After reset every source and mask bit reads 0, `irq_out` is low, the status register reads 0, and offset 0x00 reads the nonzero revision parameter (default 0x4F470102).
- R2: Endpoint group layout: bits 15:0 are transmit endpoints 0-15 and bits 31:17 are receive endpoints 1-15. Bit 16 always reads 0 in the source (0x20), mask (0x2C) and masked (0x38) registers, whatever is written or signalled.
- R3: Core group: only bits 24:16 (nine core events) can ever be 1 in the core source (0x40), mask (0x4C) and masked (0x58) registers.
- R4: Writing 1s to a source-set register (0x24 / 0x44) sets those source bits, and writing 1s to a source-clear register (0x28 / 0x48) clears them. Bits written as 0 are unchanged. Writes to the source registers themselves are ignored.
- R5: Mask bits are set through 0x30 / 0x50 and cleared through 0x34 / 0x54. The masked register (0x38 / 0x58) reads source AND mask.
- R6: A one-cycle hardware event pulse sets its source bit on the next clock edge. When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R7: `irq_out` rises one cycle after a write or event leaves a masked source pending while the line is armed. It falls one cycle after no masked source remains. Once it has risen it does not rise again until a write of any value to 0x60. After that write the line falls for one cycle and rises again if masked sources are still pending.
- R8: Writing 1 to bit 0 of the control register (0x04) clears all sources and masks, drops `irq_out` and re-arms the line. The control register reads 0, and the storage registers keep their values.
- R9: Status bit 0 (0x08) shows `vbus_drv_in` two clock edges after it changes. One edge later, core source bit 24 is set, on both rising and falling input edges.
- R10: Offsets 0x0C, 0x14, 0x18 and 0x1C are 32-bit read/write storage registers that reset to 0.
- R11: Reserved offsets (0x10, 0x3C, 0x5C, 0x64 and above) and misaligned addresses read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled at the clock edge |
| reg_addr | input | ADDR_W (8) | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ep_tx_evt | input | TX_EPS (16) | Transmit endpoint event pulses |
| ep_rx_evt | input | RX_EPS (16) | Receive endpoint event pulses; bit 0 has no effect |
| core_evt | input | CORE_EVTS (9) | Core USB event pulses |
| vbus_drv_in | input | 1 | Asynchronous VBUS-drive indication |
| irq_out | output | 1 | Level interrupt request to the CPU |

## Verification
The bench walks every bit of both groups through the set, clear, mask and hardware paths and computes the expected value from the layout rules. A design that let receive endpoint 0 through, or leaked bits outside the core field, would show a stray 1 at bit 16 or outside bits 24:16. The same-cycle hardware-set against software-clear case is driven directly. A design where the clear wins would lose the event. The interrupt line is sampled cycle by cycle around assertion, source clear and end-of-interrupt. A line that re-armed itself, or that ignored the end-of-interrupt write, would rise or fail to rise one cycle off. Soft reset, the VBUS synchronizer delay, and a sweep over all reserved and misaligned offsets complete the run. A decoder that aliased a reserved offset onto live state would change a source, mask or storage register.

// File: rtl/otg_glue_pkg.sv
package otg_glue_pkg;

  localparam int unsigned DW = 32;
  typedef logic [DW-1:0] word_t;

  // Word indices (byte offset / 4)
  localparam int unsigned W_REV  = 0;
  localparam int unsigned W_CTRL = 1;
  localparam int unsigned W_STAT = 2;
  localparam int unsigned W_EOI  = 24;
  localparam int unsigned GRP_EP   = 1;   // words 8..15
  localparam int unsigned GRP_CORE = 2;   // words 16..23
  localparam int unsigned NUM_STORE = 4;

  // Sub-register order inside an interrupt group
  localparam logic [2:0] SUB_SRC    = 3'd0;
  localparam logic [2:0] SUB_SET    = 3'd1;
  localparam logic [2:0] SUB_CLR    = 3'd2;
  localparam logic [2:0] SUB_MASK   = 3'd3;
  localparam logic [2:0] SUB_MSET   = 3'd4;
  localparam logic [2:0] SUB_MCLR   = 3'd5;
  localparam logic [2:0] SUB_MASKED = 3'd6;

  // Contiguous run of ones starting at lsb
  function automatic word_t run_mask(int unsigned lsb, int unsigned n);
    word_t r;
    for (int unsigned i = 0; i < DW; i++) r[i] = (i >= lsb) && (i < lsb + n);
    return r;
  endfunction

  // Endpoint group: TX at 0.., RX from rx_lsb with RX endpoint 0 absent
  function automatic word_t ep_valid(int unsigned tx_eps, int unsigned rx_eps,
                                     int unsigned rx_lsb);
    return run_mask(0, tx_eps) | run_mask(rx_lsb + 1, rx_eps - 1);
  endfunction

  // Hardware set is applied after the software clear, so it wins
  function automatic word_t src_next(word_t cur, word_t hw, word_t sset,
                                     word_t sclr, word_t valid);
    return (((cur & ~sclr) | sset) | hw) & valid;
  endfunction

  function automatic word_t mask_next(word_t cur, word_t mset, word_t mclr,
                                      word_t valid);
    return ((cur & ~mclr) | mset) & valid;
  endfunction

  // Word index of storage register k
  function automatic int unsigned store_word(int unsigned k);
    return (k == 0) ? 3 : k + 4;
  endfunction

endpackage

// File: rtl/otg_glue_src_bank.sv
module otg_glue_src_bank
  import otg_glue_pkg::*;
#(
  parameter word_t VALID = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_all,
  input  word_t      hw_set,
  input  logic       wr_en,
  input  logic [2:0] sub_sel,
  input  word_t      wdata,
  output word_t      src_o,
  output word_t      mask_o,
  output word_t      masked_o,
  output word_t      rdata_o
);

  word_t src_q, mask_q;
  word_t sw_set, sw_clr, m_set, m_clr;

  always_comb begin
    sw_set = (wr_en && sub_sel == SUB_SET)  ? wdata : '0;
    sw_clr = (wr_en && sub_sel == SUB_CLR)  ? wdata : '0;
    m_set  = (wr_en && sub_sel == SUB_MSET) ? wdata : '0;
    m_clr  = (wr_en && sub_sel == SUB_MCLR) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
    end else if (clr_all) begin
      src_q  <= '0;
      mask_q <= '0;
    end else begin
      src_q  <= src_next(src_q, hw_set, sw_set, sw_clr, VALID);
      mask_q <= mask_next(mask_q, m_set, m_clr, VALID);
    end
  end

  assign src_o    = src_q;
  assign mask_o   = mask_q;
  assign masked_o = src_q & mask_q;

  always_comb begin
    case (sub_sel)
      SUB_SRC:    rdata_o = src_q;
      SUB_MASK:   rdata_o = mask_q;
      SUB_MASKED: rdata_o = src_q & mask_q;
      default:    rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/otg_glue_vbus_sync.sv
module otg_glue_vbus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_o,
  output logic toggle_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o  = chain_q[STAGES-1];
  assign toggle_o = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/otg_glue_irq_line.sv
module otg_glue_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic pending,
  output logic irq_o,
  output logic armed_o
);

  logic line_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      armed_q <= 1'b1;
    end else if (rearm) begin
      line_q  <= 1'b0;
      armed_q <= 1'b1;
    end else if (armed_q && pending) begin
      line_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (!pending) begin
      line_q  <= 1'b0;
    end
  end

  assign irq_o   = line_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/otg_glue_irqc.sv
module otg_glue_irqc
  import otg_glue_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned TX_EPS      = 16,
  parameter int unsigned RX_EPS      = 16,
  parameter int unsigned RX_LSB      = 16,
  parameter int unsigned CORE_EVTS   = 9,
  parameter int unsigned CORE_LSB    = 16,
  parameter int unsigned VBUS_EVT    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] REV_ID      = 32'h4F47_0102
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [TX_EPS-1:0]    ep_tx_evt,
  input  logic [RX_EPS-1:0]    ep_rx_evt,
  input  logic [CORE_EVTS-1:0] core_evt,
  input  logic                 vbus_drv_in,
  output logic                 irq_out
);

  localparam word_t EP_VALID   = ep_valid(TX_EPS, RX_EPS, RX_LSB);
  localparam word_t CORE_VALID = run_mask(CORE_LSB, CORE_EVTS);

  // Decode
  logic              aligned;
  int unsigned       widx;
  logic              sel_ep, sel_core;
  logic [2:0]        sub_sel;
  logic              soft_rst, eoi_wr;
  word_t             ep_valid_w, core_valid_w;

  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign widx     = 32'(reg_addr[ADDR_W-1:2]);
  assign sub_sel  = reg_addr[4:2];
  assign sel_ep   = aligned && ((widx >> 3) == GRP_EP);
  assign sel_core = aligned && ((widx >> 3) == GRP_CORE);
  assign soft_rst = reg_wr && aligned && (widx == W_CTRL) && reg_wdata[0];
  assign eoi_wr   = reg_wr && aligned && (widx == W_EOI);
  assign ep_valid_w   = EP_VALID;
  assign core_valid_w = CORE_VALID;

  // Event inputs placed into register layout
  logic  vbus_lvl, vbus_edge;
  word_t ep_hw, core_hw;

  otg_glue_vbus_sync #(.STAGES(SYNC_STAGES)) u_vsync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (vbus_drv_in),
    .level_o  (vbus_lvl),
    .toggle_o (vbus_edge)
  );

  assign ep_hw   = word_t'(ep_tx_evt) | (word_t'(ep_rx_evt) << RX_LSB);
  assign core_hw = (word_t'(core_evt) << CORE_LSB) |
                   (word_t'(vbus_edge) << (CORE_LSB + VBUS_EVT));

  // Interrupt groups
  word_t ep_src, ep_mask, ep_masked, ep_rdata;
  word_t core_src, core_mask, core_masked, core_rdata;

  otg_glue_src_bank #(.VALID(EP_VALID)) u_ep_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (soft_rst),
    .hw_set   (ep_hw),
    .wr_en    (reg_wr && sel_ep),
    .sub_sel  (sub_sel),
    .wdata    (reg_wdata),
    .src_o    (ep_src),
    .mask_o   (ep_mask),
    .masked_o (ep_masked),
    .rdata_o  (ep_rdata)
  );

  otg_glue_src_bank #(.VALID(CORE_VALID)) u_core_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (soft_rst),
    .hw_set   (core_hw),
    .wr_en    (reg_wr && sel_core),
    .sub_sel  (sub_sel),
    .wdata    (reg_wdata),
    .src_o    (core_src),
    .mask_o   (core_mask),
    .masked_o (core_masked),
    .rdata_o  (core_rdata)
  );

  // Interrupt line
  logic any_pending, armed;

  assign any_pending = (|ep_masked) || (|core_masked);

  otg_glue_irq_line u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .rearm   (eoi_wr || soft_rst),
    .pending (any_pending),
    .irq_o   (irq_out),
    .armed_o (armed)
  );

  // Storage registers
  word_t store_q [NUM_STORE];
  logic [NUM_STORE-1:0] store_hit;

  for (genvar k = 0; k < NUM_STORE; k++) begin : g_store
    assign store_hit[k] = aligned && (widx == store_word(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      store_q[k] <= '0;
      else if (reg_wr && store_hit[k]) store_q[k] <= reg_wdata;
    end
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (widx == W_REV)       reg_rdata = REV_ID;
      else if (widx == W_STAT) reg_rdata = {31'b0, vbus_lvl};
      else if (sel_ep)         reg_rdata = ep_rdata;
      else if (sel_core)       reg_rdata = core_rdata;
      for (int unsigned k = 0; k < NUM_STORE; k++)
        if (store_hit[k]) reg_rdata = store_q[k];
    end
  end

endmodule

// File: rtl/otg_glue_irqc_chk.sv
module otg_glue_irqc_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              irq_out,
  input logic [31:0]       ep_src,
  input logic [31:0]       ep_mask,
  input logic [31:0]       core_src,
  input logic [31:0]       core_mask,
  input logic [31:0]       ep_hw,
  input logic              soft_rst,
  input logic              eoi_wr,
  input logic              armed,
  input logic [31:0]       ep_valid,
  input logic [31:0]       core_valid
);

  a_r2_ep_readback_layout: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(8'h20)) |-> ((reg_rdata & ~ep_valid) == 32'h0));

  a_r3_core_readback_field: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(8'h40)) |-> ((reg_rdata & ~core_valid) == 32'h0));

  a_r5_masked_view: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(8'h38)) |-> (reg_rdata == (ep_src & ep_mask)));

  a_r6_hw_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && (ep_hw != 32'h0)) |=>
      ((ep_src & $past(ep_hw & ep_valid)) == $past(ep_hw & ep_valid)));

  a_r7_rise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(armed));

  a_r7_eoi_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> !irq_out);

  a_r8_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ep_src == 32'h0 && core_src == 32'h0 && ep_mask == 32'h0 &&
                  core_mask == 32'h0 && armed && !irq_out));

endmodule

bind otg_glue_irqc otg_glue_irqc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .irq_out    (irq_out),
  .ep_src     (ep_src),
  .ep_mask    (ep_mask),
  .core_src   (core_src),
  .core_mask  (core_mask),
  .ep_hw      (ep_hw),
  .soft_rst   (soft_rst),
  .eoi_wr     (eoi_wr),
  .armed      (armed),
  .ep_valid   (ep_valid_w),
  .core_valid (core_valid_w)
);

// File: tb/otg_glue_irqc_tb_top.sv
module otg_glue_irqc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] REV  = 32'h4F47_0102;
  localparam logic [31:0] EPV  = 32'hFFFE_FFFF;
  localparam logic [31:0] COREV = 32'h01FF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [15:0] ep_tx_evt = '0;
  logic [15:0] ep_rx_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        vbus_drv_in = 1'b0;
  logic        irq_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otg_glue_irqc dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ep_tx_evt   (ep_tx_evt),
    .ep_rx_evt   (ep_rx_evt),
    .core_evt    (core_evt),
    .vbus_drv_in (vbus_drv_in),
    .irq_out     (irq_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_all_groups();
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF);
  endtask

  function automatic bit is_reserved(int w);
    return (w == 4) || (w == 15) || (w == 23) || (w > 24);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, exp, src, msk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", 32'(irq_out), 32'h0);
    rd(8'h00, d); chk("R1 revision", d, REV);
    rd(8'h20, d); chk("R1 ep src", d, 0);
    rd(8'h2C, d); chk("R1 ep mask", d, 0);
    rd(8'h40, d); chk("R1 core src", d, 0);
    rd(8'h4C, d); chk("R1 core mask", d, 0);
    rd(8'h08, d); chk("R1 status", d, 0);

    // R2 / R4 endpoint set/clear sweep
    for (int b = 0; b < 32; b++) begin
      exp = (b == 16) ? 32'h0 : (32'h1 << b);
      wr(8'h24, 32'h1 << b); rd(8'h20, d); chk("R2 R4 ep set bit", d, exp);
      wr(8'h28, 32'h1 << b); rd(8'h20, d); chk("R4 ep clear bit", d, 0);
    end
    // R3 core set/clear sweep
    for (int b = 0; b < 32; b++) begin
      exp = (b >= 16 && b <= 24) ? (32'h1 << b) : 32'h0;
      wr(8'h44, 32'h1 << b); rd(8'h40, d); chk("R3 R4 core set bit", d, exp);
      wr(8'h48, 32'h1 << b); rd(8'h40, d); chk("R4 core clear bit", d, 0);
    end
    // R4 zero bits untouched, direct source writes ignored
    wr(8'h24, 32'h0000_00F0); wr(8'h28, 32'h0000_0030);
    rd(8'h20, d); chk("R4 partial clear", d, 32'h0000_00C0);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); chk("R4 direct ep src write ignored", d, 32'h0000_00C0);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, d); chk("R4 direct core src write ignored", d, 0);

    // R5 masks and masked view
    src = 32'hA5A5_5A5A;
    wr(8'h24, src); wr(8'h30, 32'hFFFF_FFFF); wr(8'h34, 32'h0000_00FF);
    msk = EPV & ~32'h0000_00FF;
    rd(8'h2C, d); chk("R2 R5 ep mask layout", d, msk);
    rd(8'h38, d); chk("R5 ep masked", d, ((src | 32'h0000_00C0) & EPV) & msk);
    wr(8'h44, 32'h0155_0000); wr(8'h50, 32'hFFFF_FFFF); wr(8'h54, 32'h000F_0000);
    rd(8'h4C, d); chk("R3 R5 core mask field", d, COREV & ~32'h000F_0000);
    rd(8'h58, d); chk("R5 core masked", d, 32'h0150_0000);
    clear_all_groups();

    // R6 hardware event sweep
    for (int t = 0; t < 16; t++) begin
      @(negedge clk); ep_tx_evt = 16'h1 << t;
      @(negedge clk); ep_tx_evt = '0;
      rd(8'h20, d); chk("R6 tx event", d, 32'h1 << t);
      wr(8'h28, 32'hFFFF_FFFF);
    end
    for (int r = 0; r < 16; r++) begin
      @(negedge clk); ep_rx_evt = 16'h1 << r;
      @(negedge clk); ep_rx_evt = '0;
      rd(8'h20, d); chk("R2 R6 rx event", d, (r == 0) ? 32'h0 : (32'h1 << (16 + r)));
      wr(8'h28, 32'hFFFF_FFFF);
    end
    for (int c = 0; c < 9; c++) begin
      @(negedge clk); core_evt = 9'h1 << c;
      @(negedge clk); core_evt = '0;
      rd(8'h40, d); chk("R6 core event", d, 32'h1 << (16 + c));
      wr(8'h48, 32'hFFFF_FFFF);
    end
    // R6 same-cycle hw set vs sw clear
    wr(8'h24, 32'h0000_0018);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h28; reg_wdata = 32'h0000_0018; ep_tx_evt = 16'h0008;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 0; ep_tx_evt = '0;
    rd(8'h20, d); chk("R6 hw set beats sw clear", d, 32'h0000_0008);
    clear_all_groups();

    // R10 storage registers
    wr(8'h0C, 32'hA5A5_0000); wr(8'h14, 32'hA5A5_0001);
    wr(8'h18, 32'hA5A5_0002); wr(8'h1C, 32'hA5A5_0003);
    rd(8'h0C, d); chk("R10 emulation store", d, 32'hA5A5_0000);
    rd(8'h14, d); chk("R10 autoreq store", d, 32'hA5A5_0001);
    rd(8'h18, d); chk("R10 srp store", d, 32'hA5A5_0002);
    rd(8'h1C, d); chk("R10 teardown store", d, 32'hA5A5_0003);

    // R11 reserved offsets and misaligned addresses
    for (int w = 0; w < 64; w++) begin
      if (is_reserved(w)) begin
        wr(8'(w * 4), 32'hFFFF_FFFF);
        rd(8'(w * 4), d); chk("R11 reserved reads zero", d, 0);
      end
    end
    wr(8'h25, 32'hFFFF_FFFF); wr(8'h0E, 32'hFFFF_FFFF);
    rd(8'h21, d); chk("R11 misaligned read", d, 0);
    rd(8'h20, d); chk("R11 ep src untouched", d, 0);
    rd(8'h2C, d); chk("R11 ep mask untouched", d, 0);
    rd(8'h40, d); chk("R11 core src untouched", d, 0);
    rd(8'h0C, d); chk("R11 storage untouched", d, 32'hA5A5_0000);

    // R8 soft reset
    wr(8'h24, 32'h0000_0003); wr(8'h30, 32'h0000_0001); wr(8'h44, 32'h0001_0000);
    wr(8'h04, 32'h0000_0001);
    chk("R8 irq low after soft reset", 32'(irq_out), 0);
    rd(8'h20, d); chk("R8 ep src cleared", d, 0);
    rd(8'h2C, d); chk("R8 ep mask cleared", d, 0);
    rd(8'h40, d); chk("R8 core src cleared", d, 0);
    rd(8'h04, d); chk("R8 control reads zero", d, 0);
    rd(8'h18, d); chk("R8 storage retained", d, 32'hA5A5_0002);

    // R7 interrupt line sequencing (line armed by soft reset)
    wr(8'h50, 32'h0001_0000);
    chk("R7 no irq without source", 32'(irq_out), 0);
    wr(8'h44, 32'h0001_0000);
    chk("R7 irq not yet", 32'(irq_out), 0);
    @(negedge clk); chk("R7 irq rises", 32'(irq_out), 1);
    repeat (3) @(negedge clk);
    chk("R7 irq holds", 32'(irq_out), 1);
    wr(8'h48, 32'h0001_0000);
    chk("R7 irq one cycle after clear", 32'(irq_out), 1);
    @(negedge clk); chk("R7 irq falls", 32'(irq_out), 0);
    wr(8'h44, 32'h0001_0000);
    repeat (4) @(negedge clk);
    chk("R7 no re-assert before eoi", 32'(irq_out), 0);
    wr(8'h60, 32'h0);
    chk("R7 eoi cycle", 32'(irq_out), 0);
    @(negedge clk); chk("R7 re-assert after eoi", 32'(irq_out), 1);
    wr(8'h60, 32'h1234_5678);
    chk("R7 eoi drops line", 32'(irq_out), 0);
    @(negedge clk); chk("R7 pending re-asserts", 32'(irq_out), 1);
    wr(8'h48, 32'hFFFF_FFFF); wr(8'h60, 32'h0);
    wr(8'h44, 32'h0002_0000);
    repeat (3) @(negedge clk);
    chk("R7 masked-off source silent", 32'(irq_out), 0);
    clear_all_groups();

    // R9 VBUS drive synchronizer and edge event
    @(negedge clk); vbus_drv_in = 1'b1;
    @(negedge clk); reg_addr = 8'h08; #1 chk("R9 status after 1 edge", reg_rdata, 0);
    @(negedge clk); #1 chk("R9 status after 2 edges", reg_rdata, 1);
    rd(8'h40, d); chk("R9 rise sets core bit 24", d, 32'h0100_0000);
    wr(8'h48, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R9 single event per edge", d, 0);
    @(negedge clk); vbus_drv_in = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h08, d); chk("R9 status low", d, 0);
    rd(8'h40, d); chk("R9 fall sets core bit 24", d, 32'h0100_0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule